// File: doc/BRIEF.md
# Page Write Buffer Controller

This block is the write side of a byte-wide nonvolatile memory that is organised in pages. The host drives it like a static RAM, with active-low chip-enable, write-enable and output-enable strobes sampled on the clock, plus an address and a data byte. A write strobe takes its address when the strobe becomes active and its data from the last cycle it is active. The byte goes into a one-page staging buffer, and a mask bit records which byte offsets have been loaded.

Every accepted byte restarts a load window. When the host stays quiet for the whole window, the block closes the page and starts a self-timed programming interval, with `busy` high for that interval. During the interval it copies only the marked bytes into a behavioural memory array. The other bytes of that page keep what they held. A power-on lockout after reset, a programming interval in progress, and output-enable held low during a strobe all stop a write from starting. A strobe aimed at a page other than the open one is dropped and raises a sticky flag. A synchronous read port returns array contents. All durations are parameters counted in clock cycles.

Top module: `page_write_ctrl`

## Requirements
- R1: When reset is released, `busy`, `page_err` and `rdata` are all 0.
- R2: For POR_CYC cycles after reset, write strobes are ignored: nothing is stored and no programming interval starts.
- R3: A write starts when ce_n and we_n are both low while oe_n is high, whichever strobe falls last. The address is the one present in the first active cycle. The data is the value present in the last active cycle before either strobe rises.
- R4: A strobe pair that is active while oe_n is low does not load a byte.
- R5: Bytes of one page whose strobes each begin within LOAD_WIN cycles of the previous byte's end are loaded in any offset order and are programmed in a single interval.
- R6: Loading an offset a second time within the same page replaces the value loaded earlier.
- R7: During programming, page offsets that were not loaded keep their previous array contents.
- R8: With no new strobe, `busy` rises LOAD_WIN+1 cycles after the cycle in which the last byte's strobe went inactive.
- R9: `busy` stays high for exactly PROG_CYC cycles.
- R10: Write strobes issued while `busy` is high are ignored.
- R11: While a page is open, a strobe whose upper address bits (all bits above the low 7 offset bits) differ from the open page is ignored and sets `page_err`. The flag stays set until reset.
- R12: With ce_n and oe_n low and we_n high, `rdata` shows the array byte at `addr` one clock later. Otherwise `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; the low 7 bits are the offset within the page |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High during the programming interval |
| page_err | output | 1 | Sticky flag for a strobe that targeted a different page |

## Verification
The loading path is tried with four strobe patterns. In a write-enable-controlled strobe, the address and the data both change partway through the pulse, which separates capture at the start from capture at the end. A chip-enable-controlled strobe shows that either strobe may be the one that falls last. A multi-byte page is loaded out of offset order with one offset rewritten, and a single busy interval of the exact length shows that the bytes were not split across intervals. The remaining patterns are strobes that must do nothing: during lockout, during busy, with output-enable low, and to a foreign page. Each is followed by a read-back and by a check that no programming interval began.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_IDLE = 2'd1,
    ST_LOAD = 2'd2,
    ST_PROG = 2'd3
  } pwb_state_e;
endpackage

// File: rtl/pwb_por.sv
`timescale 1ns/1ps
module pwb_por #(
  parameter int CYC = 625000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CNT_W = $clog2(CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(CYC - 1)) done <= 1'b1;
    end
  end

  // R2
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
endmodule

// File: rtl/pwb_page_buf.sv
`timescale 1ns/1ps
module pwb_page_buf #(
  parameter int OFF_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_loaded
);
  localparam int BYTES = 1 << OFF_W;

  logic [DATA_W-1:0] stage [BYTES];
  logic [BYTES-1:0]  mark;

  always_ff @(posedge clk) begin
    if (wr_en) stage[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  mark <= '0;
    else if (wr_en)  mark[wr_off] <= 1'b1;
  end

  assign rd_data   = stage[rd_off];
  assign rd_loaded = mark[rd_off];

  // R5
  load_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> mark[$past(wr_off)]);
  // R7
  clear_mark_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mark == '0));
endmodule

// File: rtl/pwb_array.sv
`timescale 1ns/1ps
module pwb_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_write_ctrl.sv
`timescale 1ns/1ps
module page_write_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 7,
  parameter int LOAD_WIN = 18750,
  parameter int PROG_CYC = 1250000,
  parameter int POR_CYC  = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int WIN_W      = $clog2(LOAD_WIN + 1);
  localparam int PROG_W     = $clog2(PROG_CYC + 1);

  pwb_state_e        state, state_d;
  logic              por_done;
  logic              wr_act, wr_act_q, start, stop;
  logic              accept, viol, commit, cap_valid;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;
  logic [WIN_W-1:0]  win_cnt;
  logic [PROG_W-1:0] prog_cnt;
  logic              win_done, prog_last, copy_phase;
  logic [DATA_W-1:0] buf_data;
  logic              buf_loaded;
  logic              arr_we, rd_en;

  pwb_por #(.CYC(POR_CYC)) u_por (
    .clk(clk), .rst(rst), .done(por_done)
  );

  // strobe edge detection
  assign wr_act = ~ce_n & ~we_n & oe_n;
  assign start  = wr_act & ~wr_act_q;
  assign stop   = ~wr_act & wr_act_q;

  assign accept = start & ((state == ST_IDLE) ||
                  ((state == ST_LOAD) && (addr[ADDR_W-1:OFF_W] == page_q)));
  assign viol   = start & (state == ST_LOAD) &&
                  (addr[ADDR_W-1:OFF_W] != page_q);
  assign commit = stop & cap_valid;

  assign win_done   = (win_cnt == WIN_W'(LOAD_WIN - 1));
  assign prog_last  = (prog_cnt == PROG_W'(PROG_CYC - 1));
  assign copy_phase = (state == ST_PROG) && (prog_cnt < PROG_W'(PAGE_BYTES));

  always_comb begin
    state_d = state;
    unique case (state)
      ST_LOCK: if (por_done) state_d = ST_IDLE;
      ST_IDLE: if (accept) state_d = ST_LOAD;
      ST_LOAD: if (!cap_valid && !accept && win_done) state_d = ST_PROG;
      ST_PROG: if (prog_last) state_d = ST_IDLE;
      default: state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOCK;
      busy      <= 1'b0;
      wr_act_q  <= 1'b0;
      cap_valid <= 1'b0;
      page_err  <= 1'b0;
      page_q    <= '0;
      off_q     <= '0;
      data_q    <= '0;
    end else begin
      state    <= state_d;
      busy     <= (state_d == ST_PROG);
      wr_act_q <= wr_act;
      if (wr_act) data_q <= wdata;
      if (accept) begin
        cap_valid <= 1'b1;
        off_q     <= addr[OFF_W-1:0];
        if (state == ST_IDLE) page_q <= addr[ADDR_W-1:OFF_W];
      end else if (stop) begin
        cap_valid <= 1'b0;
      end
      if (viol) page_err <= 1'b1;
    end
  end

  // load window: restarts on each accepted byte, runs while no strobe is held
  always_ff @(posedge clk) begin
    if (rst || accept || commit)               win_cnt <= '0;
    else if (state == ST_LOAD && !cap_valid && !win_done) win_cnt <= win_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || state != ST_PROG) prog_cnt <= '0;
    else                         prog_cnt <= prog_cnt + 1'b1;
  end

  pwb_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(commit), .wr_off(off_q), .wr_data(data_q),
    .clr((state == ST_PROG) && prog_last),
    .rd_off(prog_cnt[OFF_W-1:0]),
    .rd_data(buf_data), .rd_loaded(buf_loaded)
  );

  assign arr_we = copy_phase & buf_loaded;
  assign rd_en  = ~ce_n & ~oe_n & we_n;

  pwb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst(rst),
    .we(arr_we), .waddr({page_q, prog_cnt[OFF_W-1:0]}), .wdata(buf_data),
    .re(rd_en), .raddr(addr), .rdata(rdata)
  );

  // R2
  lock_block_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK) |=> !cap_valid);
  // R9
  prog_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(prog_cnt) == PROG_W'(PROG_CYC - 1)));
  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cap_valid);
  // R11
  page_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    page_err |=> page_err);
  // R7
  copy_only_prog_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
endmodule

// File: tb/sim_page_write_ctrl.sv
`timescale 1ns/1ps
module sim_page_write_ctrl;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int LW = 40;
  localparam int PC = 200;
  localparam int PR = 100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          busy, page_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  page_write_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .OFF_W(7),
    .LOAD_WIN(LW), .PROG_CYC(PC), .POR_CYC(PR)
  ) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .page_err(page_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    logic [DW-1:0] v;
    rd_byte(a, v);
    chk(v === e, req, int'(v), int'(e));
  endtask

  task automatic wait_prog();
    for (int i = 0; i < LW + 50 && !busy; i++) @(negedge clk);
    for (int i = 0; i < PC + 50 && busy; i++) @(negedge clk);
  endtask

  task automatic quiet_chk(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < LW + 20; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(page_err == 1'b0, "R1 page_err", int'(page_err), 0);
    chk(rdata == '0, "R1 rdata", int'(rdata), 0);
  endtask

  task automatic t_lockout();
    wr_byte(10'h005, 8'hA5);
    quiet_chk("R2 no programming in lockout");
    repeat (PR) @(negedge clk);
    rd_chk(10'h005, 8'h00, "R2 lockout write ignored");
  endtask

  // address and data change inside the pulse; timing of busy
  task automatic t_single();
    int hi = 0;
    @(negedge clk);
    addr = 10'h083; wdata = 8'h11; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = 10'h0F0; wdata = 8'h3C;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    for (int m = 1; m <= LW + PC + 50; m++) begin
      @(negedge clk);
      if (busy) hi++;
      if (m == LW - 2) chk(!busy, "R8 busy early", int'(busy), 0);
      if (m == LW + 2) chk(busy, "R8 busy after window", int'(busy), 1);
    end
    chk(hi == PC, "R9 busy length", hi, PC);
    rd_chk(10'h083, 8'h3C, "R3 start address, last data");
    rd_chk(10'h0F0, 8'h00, "R3 late address not used");
  endtask

  task automatic t_ce_ctrl();
    @(negedge clk);
    addr = 10'h105; wdata = 8'h5A; oe_n = 1'b1; ce_n = 1'b1; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1;
    wait_prog();
    rd_chk(10'h105, 8'h5A, "R3 chip-enable controlled write");
  endtask

  task automatic t_oe_block();
    @(negedge clk);
    addr = 10'h106; wdata = 8'h77; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    quiet_chk("R4 no programming with oe low");
    rd_chk(10'h106, 8'h00, "R4 oe low blocks write");
  endtask

  task automatic t_page();
    int hi = 0;
    wr_byte(10'h17F, 8'hC1);
    wr_byte(10'h100, 8'hC2);
    wr_byte(10'h140, 8'hC3);
    wr_byte(10'h140, 8'hC4);
    for (int m = 0; m < LW + PC + 60; m++) begin
      @(negedge clk);
      if (busy) hi++;
    end
    chk(hi == PC, "R5 single interval", hi, PC);
    rd_chk(10'h17F, 8'hC1, "R5 byte high offset");
    rd_chk(10'h100, 8'hC2, "R5 byte low offset");
    rd_chk(10'h140, 8'hC4, "R6 reload replaces");
    rd_chk(10'h105, 8'h5A, "R7 unloaded byte kept");
    rd_chk(10'h141, 8'h00, "R7 unloaded byte untouched");
  endtask

  task automatic t_busy_block();
    wr_byte(10'h200, 8'h12);
    for (int i = 0; i < LW + 50 && !busy; i++) @(negedge clk);
    chk(busy, "R10 busy reached", int'(busy), 1);
    wr_byte(10'h201, 8'h34);
    wr_byte(10'h200, 8'h99);
    for (int i = 0; i < PC + 50 && busy; i++) @(negedge clk);
    quiet_chk("R10 no programming from ignored writes");
    rd_chk(10'h200, 8'h12, "R10 value kept");
    rd_chk(10'h201, 8'h00, "R10 busy write ignored");
  endtask

  task automatic t_page_viol();
    chk(!page_err, "R11 flag clear before", int'(page_err), 0);
    wr_byte(10'h280, 8'h21);
    wr_byte(10'h300, 8'h22);
    wr_byte(10'h281, 8'h23);
    wait_prog();
    chk(page_err, "R11 flag set", int'(page_err), 1);
    rd_chk(10'h280, 8'h21, "R11 open page byte a");
    rd_chk(10'h281, 8'h23, "R11 open page byte b");
    rd_chk(10'h300, 8'h00, "R11 foreign page ignored");
    wr_byte(10'h302, 8'h44);
    wait_prog();
    chk(page_err, "R11 flag sticky", int'(page_err), 1);
    rd_chk(10'h302, 8'h44, "R11 later page write works");
  endtask

  task automatic t_read_hold();
    logic [DW-1:0] v;
    rd_byte(10'h17F, v);
    @(negedge clk);
    addr = 10'h100;
    repeat (2) @(negedge clk);
    chk(rdata == 8'hC1, "R12 rdata holds without read", int'(rdata), 8'hC1);
    rd_chk(10'h100, 8'hC2, "R12 read after address change");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lockout();
    t_single();
    t_ce_ctrl();
    t_oe_block();
    t_page();
    t_busy_block();
    t_page_viol();
    t_read_hold();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule